// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and an external asynchronous 16-bit static RAM. The host issues one single-word request at a time. Each request is a read or a write with a 20-bit word address, write data and a per-byte lane mask. The controller turns the request into a timed cycle on the memory pins. It raises a one-clock ready pulse when the cycle is finished. For reads, a registered data word is valid from that pulse onward.

Every phase length is a whole number of system clocks. Each one is derived at elaboration time from the clock period parameter and the memory's minimum times in nanoseconds, rounding up so that every minimum is met. The write strobe is held for the longer of the pulse-width and data-setup minimums. A read keeps output enable low for the longer of the address-access and output-enable-access times, and samples the bus on the clock edge that ends that phase. After a read, the bus is left undriven for a turnaround phase so that the memory's output drivers are off before the controller drives write data.

The data pins are split into an output word, an input word and a drive enable, so that the pad ring can build the bidirectional bus.

Top module: `asram_ctl`

## Requirements
- R1: After reset, the memory strobes are all inactive: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1 and mem_be_n=2'b11. The controller does not drive the data bus (mem_dq_oe=0), req_ready=0 and rd_data=0.
- R2: A write holds mem_we_n low for exactly max(ceil(T_PWE/CLK_NS), ceil(T_SD/CLK_NS)) clocks, which is 5 at the defaults. Throughout that pulse, both chip enables are active, mem_addr equals the request address and is stable, and the write data is driven.
- R3: A write completes with req_ready at the posedge that comes ceil(T_WC/CLK_NS) clocks after the accepting edge, which is 7 at the defaults. After the pulse, the chip enables and byte enables are inactive until completion.
- R4: A read drives both chip enables active and mem_oe_n low with mem_we_n high for max(ceil(T_AA/CLK_NS), ceil(T_DOE/CLK_NS)) clocks, which is 7 at the defaults. mem_dq_in is captured on the edge that ends this phase, before mem_oe_n rises.
- R5: Byte lanes map as follows: req_mask bit 0 selects data bits 7:0 through mem_be_n bit 0 (active low), and req_mask bit 1 selects bits 15:8 through mem_be_n bit 1. For a write, only the selected lanes are enabled. For a read, an unselected lane returns zero in rd_data.
- R6: The controller never drives the data bus while mem_oe_n is low. After mem_oe_n rises, it does not drive the bus for at least ceil(T_HZOE/CLK_NS) clocks, which is 3 at the defaults. A read completes only after that turnaround, at RA+TA clocks after acceptance (10 at the defaults).
- R7: A request with req_mask=2'b00 completes with req_ready at the accepting edge itself. It causes no strobe activity and leaves memory contents unchanged.
- R8: req_ready is high for exactly one clock per completed request. No request is accepted in the clock where req_ready is high.
- R9: req_valid is sampled only while the controller is idle. Requests presented while a cycle is in progress are ignored and never reach the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 = low byte |
| req_ready | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Registered read data |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte enables, bit 0 = low byte |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
The hardest situation to reach is a write that starts straight after a read. Only that case shows whether the drive enable respects the output-disable turnaround, and whether the read sampled late enough to see settled data. The bench builds this case by issuing back-to-back requests with no idle gap. Its memory model returns garbage until output enable has been low for the full access count, so sampling even one clock early returns the wrong word. It also presents a second request while the first is still busy and then reads back the second address, which shows that the ignored request never reached the memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_PULSE = 3'd1,
        ST_WR_REC   = 3'd2,
        ST_RD_ACC   = 3'd3,
        ST_RD_TURN  = 3'd4
    } ctl_state_e;

    // whole clocks needed to cover t_ns, never less than one
    function automatic int cyc_ceil(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
    parameter int LANES = 2,
    localparam int DW   = LANES * 8
) (
    input  logic [LANES-1:0] sel_mask,
    input  logic [LANES-1:0] cap_mask,
    input  logic [DW-1:0]    bus_in,
    output logic [LANES-1:0] be_n,
    output logic [DW-1:0]    merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g]           = ~sel_mask[g];
        assign merged[g*8 +: 8]  = cap_mask[g] ? bus_in[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANES  = 2,
    parameter int CNT_W  = 4,
    parameter int WP_CYC = 5,
    parameter int WR_CYC = 2,
    parameter int RA_CYC = 7,
    parameter int TA_CYC = 3,
    localparam int DW    = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic [LANES-1:0]  lane_be_n,
    input  logic [DW-1:0]     rd_merged,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [LANES-1:0]  cap_mask,
    output logic              req_ready,
    output logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe
);
    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [LANES-1:0]  mask;
        logic [DW-1:0]     rdata;
        logic              ce_n;
        logic              ce;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic              dq_oe;
        logic              ready;
    } ctl_regs_t;

    localparam ctl_regs_t REGS_RST = '{
        st:    ST_IDLE,
        addr:  '0,
        wdata: '0,
        mask:  '0,
        rdata: '0,
        ce_n:  1'b1,
        ce:    1'b0,
        we_n:  1'b1,
        oe_n:  1'b1,
        be_n:  '1,
        dq_oe: 1'b0,
        ready: 1'b0
    };

    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.ready = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && !r_q.ready) begin
                    if (req_mask == '0) begin
                        // no lane selected: memory would be deselected anyway
                        r_d.ready = 1'b1;
                    end else begin
                        r_d.addr  = req_addr;
                        r_d.wdata = req_wdata;
                        r_d.mask  = req_mask;
                        r_d.ce_n  = 1'b0;
                        r_d.ce    = 1'b1;
                        r_d.be_n  = lane_be_n;
                        tmr_load  = 1'b1;
                        if (req_write) begin
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                            r_d.st    = ST_WR_PULSE;
                            tmr_val   = CNT_W'(WP_CYC - 1);
                        end else begin
                            r_d.oe_n = 1'b0;
                            r_d.st   = ST_RD_ACC;
                            tmr_val  = CNT_W'(RA_CYC - 1);
                        end
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    // all qualifiers drop together; data stays for hold
                    r_d.we_n = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.ce   = 1'b0;
                    r_d.be_n = '1;
                    r_d.st   = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WR_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (tmr_expired) begin
                    r_d.dq_oe = 1'b0;
                    r_d.ready = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    r_d.rdata = rd_merged;
                    r_d.oe_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.ce    = 1'b0;
                    r_d.be_n  = '1;
                    r_d.st    = ST_RD_TURN;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(TA_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    r_d.ready = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign cap_mask   = r_q.mask;
    assign req_ready  = r_q.ready;
    assign rd_data    = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_ce     = r_q.ce;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_be_n   = r_q.be_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANES  = 2,
    parameter int CLK_NS = 8,
    parameter int T_WC   = 55,
    parameter int T_PWE  = 40,
    parameter int T_SD   = 25,
    parameter int T_AA   = 55,
    parameter int T_DOE  = 25,
    parameter int T_HZOE = 20,
    localparam int DW    = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_in
);
    localparam int WP_CYC = imax(cyc_ceil(T_PWE, CLK_NS), cyc_ceil(T_SD, CLK_NS));
    localparam int WC_CYC = cyc_ceil(T_WC, CLK_NS);
    localparam int WR_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int RA_CYC = imax(cyc_ceil(T_AA, CLK_NS), cyc_ceil(T_DOE, CLK_NS));
    localparam int TA_CYC = cyc_ceil(T_HZOE, CLK_NS);
    localparam int MAX_CYC = imax(imax(WP_CYC, WR_CYC), imax(RA_CYC, TA_CYC));
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [LANES-1:0] lane_be_n;
    logic [LANES-1:0] cap_mask;
    logic [DW-1:0]    rd_merged;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_lanes #(.LANES(LANES)) u_lanes (
        .sel_mask (req_mask),
        .cap_mask (cap_mask),
        .bus_in   (mem_dq_in),
        .be_n     (lane_be_n),
        .merged   (rd_merged)
    );

    asram_fsm #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W),
        .WP_CYC (WP_CYC),
        .WR_CYC (WR_CYC),
        .RA_CYC (RA_CYC),
        .TA_CYC (TA_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_mask    (req_mask),
        .lane_be_n   (lane_be_n),
        .rd_merged   (rd_merged),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cap_mask    (cap_mask),
        .req_ready   (req_ready),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_ce_n    (mem_ce_n),
        .mem_ce      (mem_ce),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_be_n    (mem_be_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe)
    );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANES  = 2,
    parameter int CLK_NS = 8,
    parameter int T_PWE  = 40,
    parameter int T_SD   = 25,
    parameter int T_HZOE = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);
    localparam int WP = imax(cyc_ceil(T_PWE, CLK_NS), cyc_ceil(T_SD, CLK_NS));
    localparam int TA = cyc_ceil(T_HZOE, CLK_NS);

    logic [7:0] we_run;
    logic [7:0] since_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run   <= '0;
            since_oe <= 8'hFF;
        end else begin
            we_run   <= !mem_we_n ? ((we_run == 8'hFF) ? we_run : we_run + 1'b1) : 8'h00;
            since_oe <= !mem_oe_n ? 8'h00 : ((since_oe == 8'hFF) ? since_oe : since_oe + 1'b1);
        end
    end

    AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && !(&mem_be_n) && mem_dq_oe)); // R2
    AST_WR_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == 8'(WP))); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R2
    AST_DESELECT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_be_n && !mem_ce && mem_we_n && mem_oe_n)); // R3
    AST_RD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n)); // R4
    AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_oe >= 8'(TA))); // R6
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R8

endmodule

bind asram_ctl asram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .CLK_NS (CLK_NS),
    .T_PWE  (T_PWE),
    .T_SD   (T_SD),
    .T_HZOE (T_HZOE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_ctl.sv
module tb_asram_ctl;

    // expected cycle counts at 8 ns clock, from the requirements
    localparam int WP = 5;   // R2
    localparam int WC = 7;   // R3
    localparam int RA = 7;   // R4
    localparam int TA = 3;   // R6

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    asram_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- memory model (sampled away from the active edge)
    logic [15:0] model_mem [16];
    int   oe_run = 0;
    int   we_run = 0;
    int   since_oe = 255;
    logic prev_we_n = 1'b1;
    logic prev_dq_oe = 1'b0;
    logic [19:0] exp_wr_addr = '0;

    initial begin
        for (int i = 0; i < 16; i++) model_mem[i] = 16'h0000;
    end

    assign mem_dq_in = (!mem_oe_n && oe_run >= RA) ? model_mem[mem_addr[3:0]] : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && mem_ce && !mem_we_n) begin
                if (!mem_be_n[0]) model_mem[mem_addr[3:0]][7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
                if (!mem_be_n[1]) model_mem[mem_addr[3:0]][15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
                we_run = we_run + 1;
            end
            if (mem_we_n && !prev_we_n) begin
                check("R2 write pulse length", we_run, WP);
                we_run = 0;
            end
            if (mem_dq_oe && !prev_dq_oe)
                check("R6 turnaround before drive", 32'(since_oe >= TA), 1);
            since_oe = !mem_oe_n ? 0 : ((since_oe < 255) ? since_oe + 1 : since_oe);
            oe_run   = (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) ? oe_run + 1 : 0;
            prev_we_n  = mem_we_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    // ---------------- one request, returns latency in posedges
    task automatic run_req(input logic w, input logic [19:0] a, input logic [15:0] d,
                           input logic [1:0] m, output int lat, output logic act);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        exp_wr_addr = a;
        lat = 0; act = 1'b0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) req_valid = 1'b0;
            if (!mem_ce_n || mem_ce || !mem_we_n || !mem_oe_n || mem_be_n != 2'b11) act = 1'b1;
            if (!mem_we_n) check("R2 address during pulse", mem_addr, a);
            if (req_ready || lat > 60) break;
        end
        @(negedge clk);
        check("R8 ready lasts one clock", req_ready, 0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [1:0]  mask;
        logic [15:0] exp;
        logic        chk;
        logic [7:0]  lat;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 20'h00003, 16'hA55A, 2'b11, 16'h0000, 1'b0, 8'(WC+1)},     // R2 R3
        '{1'b1, 20'h12345, 16'h1234, 2'b01, 16'h0000, 1'b0, 8'(WC+1)},     // R5 low lane
        '{1'b1, 20'h12345, 16'hABCD, 2'b10, 16'h0000, 1'b0, 8'(WC+1)},     // R5 high lane
        '{1'b0, 20'h00003, 16'h0000, 2'b11, 16'hA55A, 1'b1, 8'(RA+TA+1)},  // R4
        '{1'b0, 20'h12345, 16'h0000, 2'b11, 16'hAB34, 1'b1, 8'(RA+TA+1)},  // R5
        '{1'b0, 20'h12345, 16'h0000, 2'b01, 16'h0034, 1'b1, 8'(RA+TA+1)},  // R5
        '{1'b0, 20'h12345, 16'h0000, 2'b10, 16'hAB00, 1'b1, 8'(RA+TA+1)},  // R5
        '{1'b1, 20'hFFFFF, 16'hFFFF, 2'b00, 16'h0000, 1'b0, 8'd1},         // R7
        '{1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'h0000, 1'b1, 8'(RA+TA+1)},  // R7 no write
        '{1'b1, 20'h0000F, 16'h8001, 2'b11, 16'h0000, 1'b0, 8'(WC+1)},     // R6 after read
        '{1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'h8001, 1'b1, 8'(RA+TA+1)},  // R4
        '{1'b0, 20'h0000A, 16'h0000, 2'b00, 16'h0000, 1'b0, 8'd1}          // R7 read
    };

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        while (!done_run) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int   lat;
        logic act;
        int   pulses;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        check("R1 ce_n", mem_ce_n, 1);
        check("R1 ce", mem_ce, 0);
        check("R1 we_n/oe_n", {mem_we_n, mem_oe_n}, 2'b11);
        check("R1 be_n", mem_be_n, 2'b11);
        check("R1 dq_oe", mem_dq_oe, 0);
        check("R1 ready", req_ready, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VECS[i]) begin
            run_req(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].mask, lat, act);
            check(VECS[i].wr ? "R3 write latency" : "R6 read latency", lat, VECS[i].lat);
            if (VECS[i].mask == 2'b00) check("R7 no strobe activity", act, 0);
            if (VECS[i].chk) check("R4 R5 read data", rd_data, VECS[i].exp);
        end

        // R9: a second request while busy must be ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00007; req_wdata = 16'h1111; req_mask = 2'b11;
        exp_wr_addr = 20'h00007;
        @(negedge clk);
        req_addr = 20'h00008; req_wdata = 16'h2222;
        pulses = 0;
        for (int k = 0; k < 14; k++) begin
            if (k == 4) req_valid = 1'b0;
            @(negedge clk);
            if (req_ready) pulses++;
        end
        check("R9 one completion for busy overlap", pulses, 1);
        run_req(1'b0, 20'h00008, 16'h0, 2'b11, lat, act);
        check("R9 ignored write absent", rd_data, 16'h0000);
        run_req(1'b0, 20'h00007, 16'h0, 2'b11, lat, act);
        check("R9 accepted write present", rd_data, 16'h1111);

        // R8: request held across completion is not re-accepted in the ready clock
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00007; req_mask = 2'b00;
        @(negedge clk);
        check("R8 mask-zero ready", req_ready, 1);
        @(negedge clk);
        check("R8 no accept during ready", req_ready, 0);
        req_valid = 1'b0;
        @(negedge clk);

        done_run = 1'b1;
        finish_run();
    end

endmodule